// File: doc/BRIEF.md
# Multi-Channel PWM Command Decoder

This block sits between a byte-oriented command transport and a small bank of PWM channels. It takes one framed packet at a time as a stream of bytes marked with valid and last flags. The first byte must carry a fixed identifier and the second carries an opcode. The block then either turns channels on and off from a bitmask, or loads period and compare values from repeated parameter groups. Each loaded group produces one-cycle write strobes for the addressed channel, with the 16-bit values placed on shared data buses.

Once the final byte of an accepted packet has been consumed, the block returns a four-byte reply over a valid/ready stream. The reply holds the identifier, a response code for the opcode, the mask of channels acted on and a pass flag. A packet that is too short for its opcode gets a distinct error reply and changes nothing. Channel run state is kept inside the block and is driven onto level enables, together with single-cycle start and stop pulses.

Top module: `pwm_cmd_decoder`

## Requirements
- R1: After reset every channel enable is 0, no write strobe or start/stop pulse is active, and rsp_valid is 0.
- R2: A packet whose first byte differs from the identifier (0xA5 by default), or whose opcode is not one of 0x01..0x05, is consumed up to its last byte and produces no reply and no channel activity. A one-byte packet is treated the same way.
- R3: Opcode 0x01 (start): bit i of byte 2 selects channel i. The block sets ch_enable for each selected channel, and raises ch_start_pulse[i] for one cycle only for channels that were not already running. The reply is identifier, 0x81, byte 2 echoed, 0x01.
- R4: Opcode 0x02 (stop) clears ch_enable for each selected channel, and raises ch_stop_pulse[i] for one cycle only for channels that were running. The reply is identifier, 0x82, byte 2 echoed, 0x01.
- R5: Opcode 0x03 (set-all) carries 7-byte groups: channel, period, compare A, compare B. Each 16-bit field arrives low byte first. In the cycle after a group's final byte, wr_period, wr_cmpa and wr_cmpb of that channel are high for one cycle, with the values on period_data, cmpa_data and cmpb_data. The response code is 0x83.
- R6: Opcode 0x04 (set-duty) carries 5-byte groups (channel, compare A, compare B). It strobes only wr_cmpa and wr_cmpb, and its response code is 0x84.
- R7: Opcode 0x05 (set-period) carries 3-byte groups (channel, period). It strobes only wr_period, and its response code is 0x85.
- R8: Groups are applied one after another, (length-2)/group-size of them; trailing bytes that do not form a whole group are ignored. At most one channel is written per cycle, and the reply mask byte is the OR of bit ch over every applied group.
- R9: A group whose channel byte is 3 or more (not below NCH) writes nothing, adds no mask bit, and makes the reply's result byte 0x00.
- R10: A packet shorter than its opcode's minimum (3 bytes for start and stop, 9 for set-all, 7 for set-duty, 5 for set-period) changes no channel and gets the reply identifier, the response code, 0xFF, 0x00.
- R11: rsp_valid rises in the cycle after the last byte of an accepted packet. Each reply byte holds stable while rsp_ready is low, and the four bytes go out in order with rsp_last on the fourth only.
- R12: Input bytes that arrive while a reply is pending are discarded, with no effect on channels or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a packet |
| ch_enable | output | NCH | Run level per channel |
| ch_start_pulse | output | NCH | One-cycle pulse when a channel leaves the stopped state |
| ch_stop_pulse | output | NCH | One-cycle pulse when a channel leaves the running state |
| wr_period | output | NCH | Period write strobe per channel |
| wr_cmpa | output | NCH | Compare A write strobe per channel |
| wr_cmpb | output | NCH | Compare B write strobe per channel |
| period_data | output | 16 | Period value for the active strobe |
| cmpa_data | output | 16 | Compare A value for the active strobe |
| cmpb_data | output | 16 | Compare B value for the active strobe |
| rsp_valid | output | 1 | Reply byte present |
| rsp_ready | input | 1 | Downstream accepts the reply byte |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Marks the fourth reply byte |

## Verification
A parser that loses its place within a group shows up in the first written channel. The strobes then land on the wrong channel or carry byte-swapped or shifted values in the cycle after the group's final byte. A wrong run-state bit is visible on ch_enable at once, and as a missing or extra start/stop pulse on the next command that selects that channel. Corrupt mask or pass accumulation only reaches the ports when the reply is drained, so every packet is followed by a full reply comparison under a stalling ready pattern.

// File: rtl/pwm_cmd_pkg.sv
package pwm_cmd_pkg;

  localparam int FIELD_W = 16;
  localparam int GBUF_N  = 6;

  localparam logic [7:0] OP_START   = 8'h01;
  localparam logic [7:0] OP_STOP    = 8'h02;
  localparam logic [7:0] OP_SETALL  = 8'h03;
  localparam logic [7:0] OP_SETDUTY = 8'h04;
  localparam logic [7:0] OP_SETPRD  = 8'h05;

  localparam logic [7:0] RSP_FLAG   = 8'h80;
  localparam logic [7:0] ERR_MASK   = 8'hFF;

  typedef enum logic [2:0] {
    ST_ID, ST_OP, ST_BODY, ST_SKIP, ST_RESP
  } pstate_e;

  typedef struct packed {
    logic [7:0]         ch;
    logic               has_prd;
    logic               has_a;
    logic               has_b;
    logic [FIELD_W-1:0] prd;
    logic [FIELD_W-1:0] a;
    logic [FIELD_W-1:0] b;
  } grp_t;

  function automatic logic op_known(input logic [7:0] op);
    return (op >= OP_START) && (op <= OP_SETPRD);
  endfunction

  function automatic logic op_is_enable(input logic [7:0] op);
    return (op == OP_START) || (op == OP_STOP);
  endfunction

  // bytes per parameter group, channel byte included
  function automatic logic [2:0] group_len(input logic [7:0] op);
    case (op)
      OP_SETALL:  return 3'd7;
      OP_SETDUTY: return 3'd5;
      OP_SETPRD:  return 3'd3;
      default:    return 3'd1;
    endcase
  endfunction

  function automatic logic [7:0] reply_code(input logic [7:0] op);
    return op | RSP_FLAG;
  endfunction

  function automatic logic [FIELD_W-1:0] join16(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  // f holds the data bytes of one group in arrival order
  function automatic grp_t build_group(input logic [7:0] op, input logic [7:0] ch,
                                       input logic [GBUF_N-1:0][7:0] f);
    grp_t g;
    g    = '0;
    g.ch = ch;
    case (op)
      OP_SETALL: begin
        g.has_prd = 1'b1;
        g.has_a   = 1'b1;
        g.has_b   = 1'b1;
        g.prd     = join16(f[0], f[1]);
        g.a       = join16(f[2], f[3]);
        g.b       = join16(f[4], f[5]);
      end
      OP_SETDUTY: begin
        g.has_a = 1'b1;
        g.has_b = 1'b1;
        g.a     = join16(f[0], f[1]);
        g.b     = join16(f[2], f[3]);
      end
      OP_SETPRD: begin
        g.has_prd = 1'b1;
        g.prd     = join16(f[0], f[1]);
      end
      default: g = '0;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwm_cmd_parser.sv
module pwm_cmd_parser
  import pwm_cmd_pkg::*;
#(
  parameter int         NCH     = 3,
  parameter logic [7:0] ID_BYTE = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       rsp_done,
  output logic       grp_fire,
  output logic       grp_ch_ok,
  output grp_t       grp,
  output logic       en_fire,
  output logic       en_start,
  output logic [7:0] en_mask,
  output logic       rsp_load,
  output logic [7:0] rsp_code_o,
  output logic [7:0] rsp_mask_o,
  output logic [7:0] rsp_res_o
);

  pstate_e                 state_q;
  logic [7:0]              op_q;
  logic [7:0]              ch_q;
  logic [2:0]              gpos_q;
  logic [GBUF_N-1:0][7:0]  gbuf_q;
  logic [7:0]              mask_q;
  logic                    ok_q;
  logic                    done_q;

  logic                    body_byte;
  logic                    is_en;
  logic [2:0]              glen;
  logic                    set_end;
  logic [GBUF_N-1:0][7:0]  full;
  logic [7:0]              mask_nxt;
  logic                    ok_nxt;
  logic                    done_nxt;
  logic                    short_pkt;
  logic                    op_byte;

  assign body_byte = in_valid && (state_q == ST_BODY);
  assign op_byte   = in_valid && (state_q == ST_OP);
  assign is_en     = op_is_enable(op_q);
  assign glen      = group_len(op_q);
  assign set_end   = body_byte && !is_en && (gpos_q == glen - 3'd1);

  always_comb begin
    for (int k = 0; k < GBUF_N; k++) begin
      full[k] = (int'(gpos_q) == k + 1) ? in_data : gbuf_q[k];
    end
  end

  assign grp       = build_group(op_q, ch_q, full);
  assign grp_ch_ok = int'(ch_q) < NCH;
  assign grp_fire  = set_end;

  assign en_fire   = body_byte && is_en && !done_q;
  assign en_start  = (op_q == OP_START);
  assign en_mask   = in_data;

  always_comb begin
    mask_nxt = mask_q;
    if (en_fire) begin
      mask_nxt = in_data;
    end else if (set_end && grp_ch_ok) begin
      mask_nxt = mask_q | (8'd1 << ch_q[2:0]);
    end
  end

  assign ok_nxt    = ok_q & ~(set_end & ~grp_ch_ok);
  assign done_nxt  = done_q | en_fire | set_end;

  assign rsp_load  = (body_byte && in_last) || (op_byte && in_last && op_known(in_data));
  assign short_pkt = (state_q == ST_OP) || !done_nxt;
  assign rsp_code_o = reply_code((state_q == ST_OP) ? in_data : op_q);
  assign rsp_mask_o = short_pkt ? ERR_MASK : mask_nxt;
  assign rsp_res_o  = short_pkt ? 8'h00 : {7'd0, ok_nxt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ID;
      op_q    <= '0;
      ch_q    <= '0;
      gpos_q  <= '0;
      gbuf_q  <= '0;
      mask_q  <= '0;
      ok_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_ID: begin
          if (in_valid && !in_last) begin
            state_q <= (in_data == ID_BYTE) ? ST_OP : ST_SKIP;
          end
        end
        ST_OP: begin
          if (in_valid) begin
            op_q   <= in_data;
            gpos_q <= '0;
            mask_q <= '0;
            ok_q   <= 1'b1;
            done_q <= 1'b0;
            if (!op_known(in_data)) begin
              state_q <= in_last ? ST_ID : ST_SKIP;
            end else begin
              state_q <= in_last ? ST_RESP : ST_BODY;
            end
          end
        end
        ST_BODY: begin
          if (in_valid) begin
            mask_q <= mask_nxt;
            ok_q   <= ok_nxt;
            done_q <= done_nxt;
            if (!is_en) begin
              if (gpos_q == 3'd0) begin
                ch_q <= in_data;
              end
              for (int k = 0; k < GBUF_N; k++) begin
                if (int'(gpos_q) == k + 1) begin
                  gbuf_q[k] <= in_data;
                end
              end
              gpos_q <= set_end ? 3'd0 : gpos_q + 3'd1;
            end
            if (in_last) begin
              state_q <= ST_RESP;
            end
          end
        end
        ST_SKIP: begin
          if (in_valid && in_last) begin
            state_q <= ST_ID;
          end
        end
        ST_RESP: begin
          if (rsp_done) begin
            state_q <= ST_ID;
          end
        end
        default: state_q <= ST_ID;
      endcase
    end
  end

endmodule

// File: rtl/pwm_chan_bank.sv
module pwm_chan_bank
  import pwm_cmd_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grp_fire,
  input  logic               grp_ch_ok,
  input  grp_t               grp,
  input  logic               en_fire,
  input  logic               en_start,
  input  logic [7:0]         en_mask,
  output logic [NCH-1:0]     ch_enable,
  output logic [NCH-1:0]     ch_start_pulse,
  output logic [NCH-1:0]     ch_stop_pulse,
  output logic [NCH-1:0]     wr_period,
  output logic [NCH-1:0]     wr_cmpa,
  output logic [NCH-1:0]     wr_cmpb,
  output logic [FIELD_W-1:0] period_data,
  output logic [FIELD_W-1:0] cmpa_data,
  output logic [FIELD_W-1:0] cmpb_data
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    logic sel;
    assign hit = grp_fire && (int'(grp.ch) == i);
    assign sel = en_fire && en_mask[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_enable[i]      <= 1'b0;
        ch_start_pulse[i] <= 1'b0;
        ch_stop_pulse[i]  <= 1'b0;
        wr_period[i]      <= 1'b0;
        wr_cmpa[i]        <= 1'b0;
        wr_cmpb[i]        <= 1'b0;
      end else begin
        wr_period[i]      <= hit && grp.has_prd;
        wr_cmpa[i]        <= hit && grp.has_a;
        wr_cmpb[i]        <= hit && grp.has_b;
        ch_start_pulse[i] <= sel && en_start && !ch_enable[i];
        ch_stop_pulse[i]  <= sel && !en_start && ch_enable[i];
        if (sel) begin
          ch_enable[i] <= en_start;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_data <= '0;
      cmpa_data   <= '0;
      cmpb_data   <= '0;
    end else if (grp_fire && grp_ch_ok) begin
      if (grp.has_prd) period_data <= grp.prd;
      if (grp.has_a)   cmpa_data   <= grp.a;
      if (grp.has_b)   cmpb_data   <= grp.b;
    end
  end

endmodule

// File: rtl/pwm_cmd_reply.sv
module pwm_cmd_reply #(
  parameter logic [7:0] ID_BYTE = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] code,
  input  logic [7:0] mask,
  input  logic [7:0] res,
  input  logic       rsp_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       rsp_last,
  output logic       done
);

  localparam int NBYTES = 4;
  localparam int IDX_W  = $clog2(NBYTES);

  logic [NBYTES-1:0][7:0] rbuf_q;
  logic [IDX_W-1:0]       idx_q;
  logic                   busy_q;
  logic                   at_end;

  assign at_end    = (idx_q == IDX_W'(NBYTES - 1));
  assign rsp_valid = busy_q;
  assign rsp_data  = rbuf_q[idx_q];
  assign rsp_last  = busy_q && at_end;
  assign done      = busy_q && rsp_ready && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load && !busy_q) begin
      rbuf_q <= {res, mask, code, ID_BYTE};
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && rsp_ready) begin
      idx_q  <= idx_q + 1'b1;
      if (at_end) begin
        busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_cmd_decoder.sv
module pwm_cmd_decoder
  import pwm_cmd_pkg::*;
#(
  parameter int         NCH     = 3,
  parameter logic [7:0] ID_BYTE = 8'hA5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_data,
  input  logic               in_last,
  output logic [NCH-1:0]     ch_enable,
  output logic [NCH-1:0]     ch_start_pulse,
  output logic [NCH-1:0]     ch_stop_pulse,
  output logic [NCH-1:0]     wr_period,
  output logic [NCH-1:0]     wr_cmpa,
  output logic [NCH-1:0]     wr_cmpb,
  output logic [FIELD_W-1:0] period_data,
  output logic [FIELD_W-1:0] cmpa_data,
  output logic [FIELD_W-1:0] cmpb_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [7:0]         rsp_data,
  output logic               rsp_last
);

  // internal events, named for the checker
  logic       grp_fire;
  logic       grp_ch_ok;
  grp_t       grp;
  logic       en_fire;
  logic       en_start;
  logic [7:0] en_mask;
  logic       rsp_load;
  logic       rsp_done;
  logic [7:0] rsp_code;
  logic [7:0] rsp_mask;
  logic [7:0] rsp_res;

  pwm_cmd_parser #(.NCH(NCH), .ID_BYTE(ID_BYTE)) u_parser (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_last    (in_last),
    .rsp_done   (rsp_done),
    .grp_fire   (grp_fire),
    .grp_ch_ok  (grp_ch_ok),
    .grp        (grp),
    .en_fire    (en_fire),
    .en_start   (en_start),
    .en_mask    (en_mask),
    .rsp_load   (rsp_load),
    .rsp_code_o (rsp_code),
    .rsp_mask_o (rsp_mask),
    .rsp_res_o  (rsp_res)
  );

  pwm_chan_bank #(.NCH(NCH)) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .grp_fire       (grp_fire),
    .grp_ch_ok      (grp_ch_ok),
    .grp            (grp),
    .en_fire        (en_fire),
    .en_start       (en_start),
    .en_mask        (en_mask),
    .ch_enable      (ch_enable),
    .ch_start_pulse (ch_start_pulse),
    .ch_stop_pulse  (ch_stop_pulse),
    .wr_period      (wr_period),
    .wr_cmpa        (wr_cmpa),
    .wr_cmpb        (wr_cmpb),
    .period_data    (period_data),
    .cmpa_data      (cmpa_data),
    .cmpb_data      (cmpb_data)
  );

  pwm_cmd_reply #(.ID_BYTE(ID_BYTE)) u_reply (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rsp_load),
    .code      (rsp_code),
    .mask      (rsp_mask),
    .res       (rsp_res),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .done      (rsp_done)
  );

endmodule

// File: rtl/pwm_cmd_decoder_chk.sv
module pwm_cmd_decoder_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] ch_enable,
  input logic [NCH-1:0] ch_start_pulse,
  input logic [NCH-1:0] ch_stop_pulse,
  input logic [NCH-1:0] wr_period,
  input logic [NCH-1:0] wr_cmpa,
  input logic [NCH-1:0] wr_cmpb,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [7:0]     rsp_data,
  input logic           rsp_last,
  input logic           grp_fire,
  input logic           grp_ch_ok
);

  logic [NCH-1:0] any_wr;
  assign any_wr = wr_period | wr_cmpa | wr_cmpb;

  // R3
  start_from_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_start_pulse & ~ch_enable) == '0) && ((ch_start_pulse & $past(ch_enable)) == '0));

  // R4
  stop_from_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_stop_pulse & ch_enable) == '0) && ((ch_stop_pulse & ~$past(ch_enable)) == '0));

  // R8
  one_channel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(any_wr));

  // R9
  bad_channel_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_fire && !grp_ch_ok) |=> (any_wr == '0));

  // R11
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

  // R11
  reply_last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid);

  // R12
  quiet_during_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rsp_valid)) |->
      ((any_wr == '0) && (ch_start_pulse == '0) && (ch_stop_pulse == '0)));

endmodule

bind pwm_cmd_decoder pwm_cmd_decoder_chk #(.NCH(NCH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ch_enable      (ch_enable),
  .ch_start_pulse (ch_start_pulse),
  .ch_stop_pulse  (ch_stop_pulse),
  .wr_period      (wr_period),
  .wr_cmpa        (wr_cmpa),
  .wr_cmpb        (wr_cmpb),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data),
  .rsp_last       (rsp_last),
  .grp_fire       (grp_fire),
  .grp_ch_ok      (grp_ch_ok)
);

// File: tb/pwm_cmd_decoder_test.sv
`timescale 1ns/1ps
module pwm_cmd_decoder_test;

  localparam int         NCH = 3;
  localparam logic [7:0] ID  = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic        rsp_ready = 1'b0;
  logic [NCH-1:0] ch_enable, ch_start_pulse, ch_stop_pulse;
  logic [NCH-1:0] wr_period, wr_cmpa, wr_cmpb;
  logic [15:0] period_data, cmpa_data, cmpb_data;
  logic        rsp_valid, rsp_last;
  logic [7:0]  rsp_data;

  always #2 clk = ~clk;

  pwm_cmd_decoder #(.NCH(NCH), .ID_BYTE(ID)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .ch_enable(ch_enable), .ch_start_pulse(ch_start_pulse), .ch_stop_pulse(ch_stop_pulse),
    .wr_period(wr_period), .wr_cmpa(wr_cmpa), .wr_cmpb(wr_cmpb),
    .period_data(period_data), .cmpa_data(cmpa_data), .cmpb_data(cmpb_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard queues
  logic [7:0] exp_b[$];
  logic       exp_l[$];
  string      exp_bt[$];
  int         ew_ch[$];
  logic [2:0] ew_kind[$];
  logic [15:0] ew_p[$], ew_a[$], ew_b[$];
  string      ew_t[$];

  logic [2:0] run_m = 3'b000;
  int st_exp[3], sp_exp[3], st_cnt[3], sp_cnt[3];
  logic [7:0] pkt[$];
  int ready_mode = 2;
  logic [7:0] lfsr = 8'h5B;

  initial begin
    for (int i = 0; i < 3; i++) begin
      st_exp[i] = 0; sp_exp[i] = 0; st_cnt[i] = 0; sp_cnt[i] = 0;
    end
  end

  // ready pattern, driven away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = (ready_mode == 0) ? lfsr[0] : (ready_mode == 2);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid && rsp_ready) begin
        if (exp_b.size() == 0) begin
          check(1'b0, "R2/R12", "unexpected reply byte", {24'd0, rsp_data}, 32'd0);
        end else begin
          logic [7:0] eb;
          logic el;
          string et;
          eb = exp_b.pop_front(); el = exp_l.pop_front(); et = exp_bt.pop_front();
          check(rsp_data == eb, et, "reply byte", {24'd0, rsp_data}, {24'd0, eb});
          check(rsp_last == el, "R11", "rsp_last", {31'd0, rsp_last}, {31'd0, el});
        end
      end
      if ((wr_period | wr_cmpa | wr_cmpb) != '0) begin
        if (ew_ch.size() == 0) begin
          check(1'b0, "R9/R10", "unexpected write", {29'd0, wr_period | wr_cmpa | wr_cmpb}, 32'd0);
        end else begin
          int c;
          logic [2:0] k;
          logic [15:0] p, a, b;
          string t;
          c = ew_ch.pop_front(); k = ew_kind.pop_front();
          p = ew_p.pop_front(); a = ew_a.pop_front(); b = ew_b.pop_front(); t = ew_t.pop_front();
          check(wr_period == (k[2] ? 3'b001 << c : 3'b000), t, "wr_period", {29'd0, wr_period}, {29'd0, k[2] ? 3'b001 << c : 3'b000});
          check(wr_cmpa == (k[1] ? 3'b001 << c : 3'b000), t, "wr_cmpa", {29'd0, wr_cmpa}, {29'd0, k[1] ? 3'b001 << c : 3'b000});
          check(wr_cmpb == (k[0] ? 3'b001 << c : 3'b000), t, "wr_cmpb", {29'd0, wr_cmpb}, {29'd0, k[0] ? 3'b001 << c : 3'b000});
          if (k[2]) check(period_data == p, t, "period_data", {16'd0, period_data}, {16'd0, p});
          if (k[1]) check(cmpa_data == a, t, "cmpa_data", {16'd0, cmpa_data}, {16'd0, a});
          if (k[0]) check(cmpb_data == b, t, "cmpb_data", {16'd0, cmpb_data}, {16'd0, b});
        end
      end
      for (int i = 0; i < 3; i++) begin
        if (ch_start_pulse[i]) st_cnt[i]++;
        if (ch_stop_pulse[i])  sp_cnt[i]++;
      end
    end
  end

  task automatic push_rsp(input logic [7:0] b, input logic l, input string t);
    exp_b.push_back(b); exp_l.push_back(l); exp_bt.push_back(t);
  endtask

  task automatic push_wr(input int c, input logic [2:0] k, input logic [15:0] p,
                         input logic [15:0] a, input logic [15:0] b, input string t);
    ew_ch.push_back(c); ew_kind.push_back(k);
    ew_p.push_back(p); ew_a.push_back(a); ew_b.push_back(b); ew_t.push_back(t);
  endtask

  function automatic logic [15:0] le16(input int at);
    return {pkt[at + 1], pkt[at]};
  endfunction

  // reference: what the packet in pkt should cause
  task automatic model_pkt(input string tag);
    int n;
    int glen;
    int groups;
    logic [7:0] op;
    logic [7:0] mask;
    logic ok;
    logic sh;
    n = pkt.size();
    if (n < 2 || pkt[0] != ID) return;
    op = pkt[1];
    if (op < 8'h01 || op > 8'h05) return;
    mask = 8'h00; ok = 1'b1;
    if (op <= 8'h02) begin
      sh = (n < 3);
      if (!sh) begin
        mask = pkt[2];
        for (int i = 0; i < 3; i++) begin
          if (mask[i]) begin
            if (op == 8'h01 && !run_m[i]) st_exp[i]++;
            if (op == 8'h02 && run_m[i])  sp_exp[i]++;
            run_m[i] = (op == 8'h01);
          end
        end
      end
    end else begin
      glen = (op == 8'h03) ? 7 : (op == 8'h04) ? 5 : 3;
      groups = (n - 2) / glen;
      sh = (groups == 0);
      for (int g = 0; g < groups; g++) begin
        int base;
        int c;
        base = 2 + g * glen;
        c = int'(pkt[base]);
        if (c >= NCH) begin
          ok = 1'b0;
        end else begin
          mask[c] = 1'b1;
          if (op == 8'h03) push_wr(c, 3'b111, le16(base + 1), le16(base + 3), le16(base + 5), tag);
          if (op == 8'h04) push_wr(c, 3'b011, 16'h0, le16(base + 1), le16(base + 3), tag);
          if (op == 8'h05) push_wr(c, 3'b100, le16(base + 1), 16'h0, 16'h0, tag);
        end
      end
    end
    push_rsp(ID, 1'b0, tag);
    push_rsp(op | 8'h80, 1'b0, tag);
    push_rsp(sh ? 8'hFF : mask, 1'b0, tag);
    push_rsp(sh ? 8'h00 : {7'd0, ok}, 1'b1, tag);
  endtask

  task automatic drive_pkt(input logic gaps);
    for (int i = 0; i < pkt.size(); i++) begin
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == pkt.size() - 1);
      @(posedge clk); #1;
      if (gaps) begin
        in_valid = 1'b0; in_last = 1'b0;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    @(negedge clk);
    while ((exp_b.size() != 0 || ew_ch.size() != 0 || rsp_valid) && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check(guard < 3000, "R11", "reply drained", guard, 0);
    @(posedge clk); #1;
  endtask

  task automatic check_state(input string tag);
    check(ch_enable == run_m, tag, "ch_enable", {29'd0, ch_enable}, {29'd0, run_m});
    for (int i = 0; i < 3; i++) begin
      check(st_cnt[i] == st_exp[i], tag, "start pulses", st_cnt[i], st_exp[i]);
      check(sp_cnt[i] == sp_exp[i], tag, "stop pulses", sp_cnt[i], sp_exp[i]);
    end
  endtask

  task automatic run_pkt(input string tag, input logic gaps);
    model_pkt(tag);
    drive_pkt(gaps);
    drain();
    check_state(tag);
  endtask

  task automatic add16(input logic [15:0] v);
    pkt.push_back(v[7:0]); pkt.push_back(v[15:8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(ch_enable == 3'b000, "R1", "ch_enable", {29'd0, ch_enable}, 0);
    check((wr_period | wr_cmpa | wr_cmpb | ch_start_pulse | ch_stop_pulse) == 3'b000, "R1", "strobes",
          {29'd0, wr_period | wr_cmpa | wr_cmpb | ch_start_pulse | ch_stop_pulse}, 0);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5 single set-all group, low byte first; R11 valid right after last byte
    pkt = '{ID, 8'h03, 8'h00};
    add16(16'h1234); add16(16'h0056); add16(16'hABCD);
    model_pkt("R5");
    drive_pkt(1'b0);
    check(rsp_valid == 1'b1, "R11", "rsp_valid after last", {31'd0, rsp_valid}, 1);
    drain();
    check_state("R5");

    // R6 R8 set-duty, two groups, random ready
    ready_mode = 0;
    pkt = '{ID, 8'h04, 8'h01};
    add16(16'h0FA0); add16(16'h7001);
    pkt.push_back(8'h02); add16(16'hFFFF); add16(16'h0000);
    run_pkt("R6", 1'b0);

    // R7 set-period with byte gaps
    pkt = '{ID, 8'h05, 8'h02};
    add16(16'hF423);
    run_pkt("R7", 1'b1);

    // R8 two set-all groups plus trailing partial group
    pkt = '{ID, 8'h03, 8'h02};
    add16(16'h1111); add16(16'h2222); add16(16'h3333);
    pkt.push_back(8'h01); add16(16'h4444); add16(16'h5555); add16(16'h6666);
    pkt.push_back(8'h00); add16(16'h7777);
    run_pkt("R8", 1'b0);

    // R9 bad channel among good groups
    pkt = '{ID, 8'h04, 8'h05};
    add16(16'h0101); add16(16'h0202);
    pkt.push_back(8'h00); add16(16'h0303); add16(16'h0404);
    run_pkt("R9", 1'b0);
    pkt = '{ID, 8'h05, 8'h03};
    add16(16'h9999);
    run_pkt("R9", 1'b0);

    // R3 start, then start again with overlap
    pkt = '{ID, 8'h01, 8'h05};
    run_pkt("R3", 1'b0);
    pkt = '{ID, 8'h01, 8'h07, 8'h33};
    run_pkt("R3", 1'b1);

    // R4 stop, then stop a channel already stopped
    pkt = '{ID, 8'h02, 8'h03};
    run_pkt("R4", 1'b0);
    pkt = '{ID, 8'h02, 8'h02};
    run_pkt("R4", 1'b0);

    // R10 short packets
    pkt = '{ID, 8'h03, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    run_pkt("R10", 1'b0);
    pkt = '{ID, 8'h01};
    run_pkt("R10", 1'b0);
    pkt = '{ID, 8'h05, 8'h00, 8'h12};
    run_pkt("R10", 1'b0);
    pkt = '{ID, 8'h02};
    run_pkt("R10", 1'b0);

    // R2 wrong identifier, unknown opcode, single byte
    pkt = '{8'h5A, 8'h01, 8'h07};
    run_pkt("R2", 1'b0);
    pkt = '{ID, 8'h09, 8'h07};
    run_pkt("R2", 1'b0);
    pkt = '{ID};
    run_pkt("R2", 1'b0);
    pkt = '{ID, 8'h00};
    run_pkt("R2", 1'b0);

    // R12 bytes during a pending reply are dropped
    ready_mode = 1;
    @(posedge clk); #1;
    pkt = '{ID, 8'h01, 8'h01};
    model_pkt("R12");
    drive_pkt(1'b0);
    pkt = '{ID, 8'h03, 8'h00};
    add16(16'hDEAD); add16(16'hBEEF); add16(16'hCAFE);
    drive_pkt(1'b0);
    pkt = '{ID, 8'h01, 8'h02};
    drive_pkt(1'b0);
    check(ch_enable == run_m, "R12", "ch_enable while reply held", {29'd0, ch_enable}, {29'd0, run_m});
    check(rsp_valid == 1'b1, "R11", "reply held", {31'd0, rsp_valid}, 1);
    ready_mode = 0;
    drain();
    check_state("R12");

    // packet right after, to confirm the parser resynchronised
    pkt = '{ID, 8'h05, 8'h01};
    add16(16'h00C8);
    run_pkt("R7", 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule